// File: doc/BRIEF.md
# AHB-Lite to Peripheral Bus Bridge

This block sits on an AHB-Lite bus as a slave and turns every accepted transfer into one access on a simple peripheral bus. Each peripheral access has two parts. A setup cycle asserts select. An enable cycle follows and lasts until the peripheral reports ready. The AHB data phase is held with the ready output low for the whole peripheral access. It is released only once the peripheral has answered. A fault reported by the peripheral comes back to the AHB master as the two-cycle ERROR response.

The address, direction and transfer size are registered when the address phase is accepted. The peripheral access is driven only from these registered copies. The AHB address bus can then move on to the next transfer while the current one is still in progress. Write data is taken from the AHB write bus during the data phase. Read data is registered when the peripheral answers and is presented in the cycle the AHB ready output returns high. Bursts reach the peripheral as a chain of single accesses. When a transfer is pending, the next access setup starts straight from the completion cycle.

Top module: `ahb_periph_bridge`

## Requirements
- R1: After reset, and whenever reset is asserted (even in the middle of an access), `ahb_ready_out` is 1, `ahb_resp` is 0 (OKAY), and `dn_sel` and `dn_en` are 0.
- R2: A selected transfer with `ahb_trans` equal to 2'b00 (IDLE) or 2'b01 (BUSY), and any transfer with `ahb_sel` low, gets a zero-wait OKAY response and starts no peripheral access.
- R3: A transfer with `ahb_trans` equal to 2'b10 (NONSEQ) or 2'b11 (SEQ) that is accepted gives, in the next cycle, exactly one cycle with `dn_sel`=1 and `dn_en`=0.
- R4: After the setup cycle, `dn_sel` and `dn_en` are both 1 and stay high until the cycle in which `dn_ready` is 1.
- R5: `dn_addr`, `dn_write` and `dn_size` carry the address, direction and size of the accepted address phase for the whole access, even after `ahb_addr`, `ahb_write` and `ahb_size` have changed.
- R6: On a write, `dn_wdata` carries the `ahb_wdata` value from the data phase and holds it steady through the enable cycles.
- R7: `ahb_ready_out` is low from the cycle after acceptance until the peripheral completes; with a ready delay of W enable cycles beyond the first, the data phase lasts W+2 low cycles followed by one high cycle. On a read, `ahb_rdata` holds the peripheral data in that high cycle.
- R8: If `dn_err` is 1 together with `dn_ready`, the next cycle shows `ahb_resp`=1 with `ahb_ready_out`=0, and the cycle after that shows `ahb_resp`=1 with `ahb_ready_out`=1.
- R9: A transfer presented while the bridge holds the bus is accepted only in the cycle `ahb_ready_out` is high. Its setup cycle follows directly, with no idle cycle between.
- R10: The beats of a SEQ burst become back-to-back single peripheral accesses, each with its own beat address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both bus sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| ahb_sel | input | 1 | Slave select from the address decoder |
| ahb_ready_in | input | 1 | Bus-level ready; an address phase is taken only when it is high |
| ahb_trans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| ahb_addr | input | ADDR_W | Address-phase address |
| ahb_write | input | 1 | Address-phase direction, 1 for write |
| ahb_size | input | 3 | Address-phase transfer size |
| ahb_wdata | input | DATA_W | Write data, valid in the data phase |
| ahb_rdata | output | DATA_W | Read data returned to the master |
| ahb_ready_out | output | 1 | Low while the data phase is held |
| ahb_resp | output | 1 | 0 OKAY, 1 ERROR |
| dn_sel | output | 1 | Peripheral select |
| dn_en | output | 1 | Peripheral enable, high in the access part |
| dn_write | output | 1 | Peripheral direction, 1 for write |
| dn_addr | output | ADDR_W | Peripheral address (registered) |
| dn_size | output | 3 | Peripheral transfer size (registered) |
| dn_wdata | output | DATA_W | Peripheral write data |
| dn_rdata | input | DATA_W | Peripheral read data |
| dn_ready | input | 1 | Peripheral completes the access |
| dn_err | input | 1 | Peripheral reports a fault, sampled with ready |

## Verification
The bench builds the bridge with its defaults: a 16-bit address and a 32-bit data path. The bench peripheral model returns the bitwise inverse of the address in the upper half of each read word and the address itself in the lower half. A read at any address therefore gives a word that a misrouted address or a stale register cannot reproduce. The 16-bit address lets the bench park a distinct value such as 16'hDEAD on the address bus during the data phase, so a capture fault shows up as a wrong logged address. The programmable ready delay ranges from zero to several enable cycles, which covers both the shortest two-cycle hold and a longer hold during which a pipelined transfer waits on the bus.

// File: rtl/ahbpb_pkg.sv
package ahbpb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_ERR,
        ST_DONE
    } bridge_state_e;

    localparam logic [1:0] HT_IDLE   = 2'b00;
    localparam logic [1:0] HT_BUSY   = 2'b01;
    localparam logic [1:0] HT_NONSEQ = 2'b10;
    localparam logic [1:0] HT_SEQ    = 2'b11;

endpackage

// File: rtl/ahbpb_ctrl.sv
module ahbpb_ctrl
    import ahbpb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ahb_sel,
    input  logic              ahb_ready_in,
    input  logic [1:0]        ahb_trans,
    input  logic [ADDR_W-1:0] ahb_addr,
    input  logic              ahb_write,
    input  logic [2:0]        ahb_size,
    input  logic              dn_ready,
    input  logic              dn_err,
    output logic [ADDR_W-1:0] addr_q,
    output logic              write_q,
    output logic [2:0]        size_q,
    output logic              ready_out,
    output logic              resp_err,
    output logic              sel,
    output logic              en,
    output logic              in_setup,
    output logic              rd_capture
);

    typedef struct packed {
        bridge_state_e     st;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [2:0]        sz;
        logic              err;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{ST_IDLE, '0, 1'b0, 3'b000, 1'b0};

    ctrl_t ctrl_d, ctrl_q;
    logic  free, real_xfer, take;

    // The bridge may take a new address phase only while the data phase is not held
    assign free      = (ctrl_q.st == ST_IDLE) || (ctrl_q.st == ST_DONE);
    assign real_xfer = (ahb_trans == HT_NONSEQ) || (ahb_trans == HT_SEQ);
    assign take      = ahb_sel && ahb_ready_in && free && real_xfer;

    always_comb begin
        ctrl_d = ctrl_q;
        case (ctrl_q.st)
            ST_IDLE, ST_DONE: begin
                ctrl_d.err = 1'b0;
                ctrl_d.st  = ST_IDLE;
                if (take) begin
                    ctrl_d.st   = ST_SETUP;
                    ctrl_d.addr = ahb_addr;
                    ctrl_d.wr   = ahb_write;
                    ctrl_d.sz   = ahb_size;
                end
            end
            ST_SETUP: begin
                ctrl_d.st = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (dn_ready) begin
                    ctrl_d.err = dn_err;
                    ctrl_d.st  = dn_err ? ST_ERR : ST_DONE;
                end
            end
            ST_ERR: begin
                ctrl_d.st = ST_DONE;
            end
            default: begin
                ctrl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign addr_q     = ctrl_q.addr;
    assign write_q    = ctrl_q.wr;
    assign size_q     = ctrl_q.sz;
    assign ready_out  = free;
    assign resp_err   = (ctrl_q.st == ST_ERR) || ((ctrl_q.st == ST_DONE) && ctrl_q.err);
    assign sel        = (ctrl_q.st == ST_SETUP) || (ctrl_q.st == ST_ACCESS);
    assign en         = (ctrl_q.st == ST_ACCESS);
    assign in_setup   = (ctrl_q.st == ST_SETUP);
    assign rd_capture = (ctrl_q.st == ST_ACCESS) && dn_ready;

endmodule

// File: rtl/ahbpb_data.sv
module ahbpb_data #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_setup,
    input  logic              rd_capture,
    input  logic [DATA_W-1:0] ahb_wdata,
    input  logic [DATA_W-1:0] dn_rdata,
    output logic [DATA_W-1:0] dn_wdata,
    output logic [DATA_W-1:0] rdata_q
);

    typedef struct packed {
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] rd;
    } dat_t;

    dat_t dat_d, dat_q;

    always_comb begin
        dat_d = dat_q;
        // Write data is only valid in the data phase: the setup cycle is its first cycle
        if (in_setup) begin
            dat_d.wd = ahb_wdata;
        end
        if (rd_capture) begin
            dat_d.rd = dn_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= '0;
        end else begin
            dat_q <= dat_d;
        end
    end

    // In setup the held bus value is passed through; afterwards the register keeps it
    assign dn_wdata = in_setup ? ahb_wdata : dat_q.wd;
    assign rdata_q  = dat_q.rd;

endmodule

// File: rtl/ahb_periph_bridge.sv
module ahb_periph_bridge #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ahb_sel,
    input  logic              ahb_ready_in,
    input  logic [1:0]        ahb_trans,
    input  logic [ADDR_W-1:0] ahb_addr,
    input  logic              ahb_write,
    input  logic [2:0]        ahb_size,
    input  logic [DATA_W-1:0] ahb_wdata,
    output logic [DATA_W-1:0] ahb_rdata,
    output logic              ahb_ready_out,
    output logic              ahb_resp,
    output logic              dn_sel,
    output logic              dn_en,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [2:0]        dn_size,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic              dn_ready,
    input  logic              dn_err
);

    logic in_setup;
    logic rd_capture;

    ahbpb_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ahb_sel      (ahb_sel),
        .ahb_ready_in (ahb_ready_in),
        .ahb_trans    (ahb_trans),
        .ahb_addr     (ahb_addr),
        .ahb_write    (ahb_write),
        .ahb_size     (ahb_size),
        .dn_ready     (dn_ready),
        .dn_err       (dn_err),
        .addr_q       (dn_addr),
        .write_q      (dn_write),
        .size_q       (dn_size),
        .ready_out    (ahb_ready_out),
        .resp_err     (ahb_resp),
        .sel          (dn_sel),
        .en           (dn_en),
        .in_setup     (in_setup),
        .rd_capture   (rd_capture)
    );

    ahbpb_data #(
        .DATA_W (DATA_W)
    ) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_setup   (in_setup),
        .rd_capture (rd_capture),
        .ahb_wdata  (ahb_wdata),
        .dn_rdata   (dn_rdata),
        .dn_wdata   (dn_wdata),
        .rdata_q    (ahb_rdata)
    );

endmodule

// File: rtl/ahbpb_checker.sv
module ahbpb_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ahb_sel,
    input logic              ahb_ready_in,
    input logic [1:0]        ahb_trans,
    input logic              ahb_ready_out,
    input logic              ahb_resp,
    input logic              dn_sel,
    input logic              dn_en,
    input logic              dn_ready,
    input logic              dn_err,
    input logic              dn_write,
    input logic [ADDR_W-1:0] dn_addr,
    input logic [DATA_W-1:0] dn_wdata
);

    logic no_xfer;
    assign no_xfer = (ahb_trans == 2'b00) || (ahb_trans == 2'b01) || !ahb_sel;

    // R2: an idle, busy or unselected address phase leads to no access and an OKAY ready
    a_r2_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (ahb_ready_in && ahb_ready_out && no_xfer) |=> (!dn_sel && ahb_ready_out && !ahb_resp));

    // R3: the setup cycle lasts exactly one cycle and moves into enable
    a_r3_setup_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_sel && !dn_en) |=> (dn_sel && dn_en));

    // R4: enable is held until the peripheral is ready
    a_r4_enable_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_sel && dn_en && !dn_ready) |=> (dn_sel && dn_en));

    // R5: the peripheral address does not move during the access
    a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_sel && dn_en) |-> $stable(dn_addr));

    // R6: write data is steady through the enable cycles
    a_r6_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_sel && dn_en && dn_write) |-> $stable(dn_wdata));

    // R7: the AHB data phase is held for as long as the peripheral is selected
    a_r7_hold_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
        dn_sel |-> !ahb_ready_out);

    // R7: a clean completion releases the data phase with OKAY
    a_r7_release_okay: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_sel && dn_en && dn_ready && !dn_err) |=> (ahb_ready_out && !ahb_resp));

    // R8: a fault starts the first ERROR cycle
    a_r8_err_first: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_sel && dn_en && dn_ready && dn_err) |=> (ahb_resp && !ahb_ready_out));

    // R8: the first ERROR cycle is always followed by the second
    a_r8_err_second: assert property (@(posedge clk) disable iff (!rst_n)
        (ahb_resp && !ahb_ready_out) |=> (ahb_resp && ahb_ready_out));

endmodule

bind ahb_periph_bridge ahbpb_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ahb_sel       (ahb_sel),
    .ahb_ready_in  (ahb_ready_in),
    .ahb_trans     (ahb_trans),
    .ahb_ready_out (ahb_ready_out),
    .ahb_resp      (ahb_resp),
    .dn_sel        (dn_sel),
    .dn_en         (dn_en),
    .dn_ready      (dn_ready),
    .dn_err        (dn_err),
    .dn_write      (dn_write),
    .dn_addr       (dn_addr),
    .dn_wdata      (dn_wdata)
);

// File: tb/ahb_periph_bridge_bench.sv
`timescale 1ns/1ps
module ahb_periph_bridge_bench;

    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ahb_sel = 1'b0;
    logic [1:0]    ahb_trans = 2'b00;
    logic [AW-1:0] ahb_addr = '0;
    logic          ahb_write = 1'b0;
    logic [2:0]    ahb_size = 3'd2;
    logic [DW-1:0] ahb_wdata = '0;
    logic [DW-1:0] ahb_rdata;
    logic          ahb_ready_out;
    logic          ahb_resp;
    logic          dn_sel, dn_en, dn_write;
    logic [AW-1:0] dn_addr;
    logic [2:0]    dn_size;
    logic [DW-1:0] dn_wdata;
    logic [DW-1:0] dn_rdata = '0;
    logic          dn_ready = 1'b0;
    logic          dn_err = 1'b0;

    always #4 clk = ~clk;

    ahb_periph_bridge #(.ADDR_W(AW), .DATA_W(DW)) u_ahb_periph_bridge (
        .clk           (clk),
        .rst_n         (rst_n),
        .ahb_sel       (ahb_sel),
        .ahb_ready_in  (ahb_ready_out),
        .ahb_trans     (ahb_trans),
        .ahb_addr      (ahb_addr),
        .ahb_write     (ahb_write),
        .ahb_size      (ahb_size),
        .ahb_wdata     (ahb_wdata),
        .ahb_rdata     (ahb_rdata),
        .ahb_ready_out (ahb_ready_out),
        .ahb_resp      (ahb_resp),
        .dn_sel        (dn_sel),
        .dn_en         (dn_en),
        .dn_write      (dn_write),
        .dn_addr       (dn_addr),
        .dn_size       (dn_size),
        .dn_wdata      (dn_wdata),
        .dn_rdata      (dn_rdata),
        .dn_ready      (dn_ready),
        .dn_err        (dn_err)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit done_flag = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
        return {~a, a};
    endfunction

    // Peripheral model: ready after cfg_wait extra enable cycles
    int            cfg_wait = 0;
    logic          cfg_err = 1'b0;
    int            acc_cnt = 0;
    int            n_setups = 0;
    int            log_n = 0;
    logic [AW-1:0] log_addr [16];
    logic [DW-1:0] log_data [16];
    logic          log_wr   [16];
    logic [2:0]    log_sz   [16];

    always @(negedge clk) begin
        if (!rst_n) begin
            dn_ready = 1'b0;
            dn_err   = 1'b0;
            acc_cnt  = 0;
        end else if (dn_sel && dn_en) begin
            if (acc_cnt == cfg_wait) begin
                dn_ready = 1'b1;
                dn_err   = cfg_err;
                dn_rdata = model(dn_addr);
                log_addr[log_n % 16] = dn_addr;
                log_data[log_n % 16] = dn_wdata;
                log_wr[log_n % 16]   = dn_write;
                log_sz[log_n % 16]   = dn_size;
                log_n++;
                acc_cnt = 0;
            end else begin
                dn_ready = 1'b0;
                acc_cnt++;
            end
        end else begin
            dn_ready = 1'b0;
            dn_err   = 1'b0;
            acc_cnt  = 0;
            if (dn_sel) n_setups++;
        end
    end

    // Per-beat results of the last sequence
    int          res_low    [8];
    logic        res_errlow [8];
    logic [DW-1:0] res_rd   [8];
    logic        res_resp   [8];

    task automatic run_seq(input int n, input logic wr, input logic [AW-1:0] base,
                           input logic [DW-1:0] dbase, input logic seq_beats,
                           input logic [2:0] sz, input int wt, input logic er);
        @(negedge clk); #1;
        cfg_wait  = wt;
        cfg_err   = er;
        ahb_sel   = 1'b1;
        ahb_trans = 2'b10;
        ahb_addr  = base;
        ahb_write = wr;
        ahb_size  = sz;
        @(posedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            ahb_wdata = dbase + DW'(i);
            if (i + 1 < n) begin
                ahb_trans = seq_beats ? 2'b11 : 2'b10;
                ahb_addr  = base + AW'(4 * (i + 1));
            end else begin
                ahb_trans = 2'b00;
                ahb_addr  = 16'hDEAD;
                ahb_write = ~wr;
                ahb_size  = 3'd0;
            end
            res_low[i]    = 0;
            res_errlow[i] = 1'b0;
            while (!ahb_ready_out) begin
                res_low[i]++;
                res_errlow[i] = res_errlow[i] | ahb_resp;
                @(posedge clk);
                @(negedge clk); #1;
            end
            res_rd[i]   = ahb_rdata;
            res_resp[i] = ahb_resp;
            @(posedge clk);
        end
    endtask

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [3:0]    wt;
        logic          er;
    } vec_t;

    localparam vec_t VEC [0:5] = '{
        '{1'b1, 16'h0010, 32'h1111_2222, 4'd0, 1'b0},
        '{1'b0, 16'h0010, 32'h0000_0000, 4'd0, 1'b0},
        '{1'b1, 16'h0124, 32'hCAFE_F00D, 4'd3, 1'b0},
        '{1'b0, 16'h0FF8, 32'h0000_0000, 4'd2, 1'b0},
        '{1'b1, 16'h0200, 32'h0BAD_BEEF, 4'd1, 1'b1},
        '{1'b0, 16'h0300, 32'h0000_0000, 4'd0, 1'b1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int base_log;
        int base_setups;

        // R1: reset state
        #1;
        chk(ahb_ready_out == 1'b1, "R1 ready after reset", 64'(ahb_ready_out), 1);
        chk(ahb_resp == 1'b0, "R1 resp after reset", 64'(ahb_resp), 0);
        chk(!dn_sel && !dn_en, "R1 peripheral idle after reset", 64'({dn_sel, dn_en}), 0);
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        rst_n = 1'b1;

        // Table walk: single transfers (R3, R4, R5, R6, R7, R8)
        for (int v = 0; v < 6; v++) begin
            base_log = log_n;
            run_seq(1, VEC[v].wr, VEC[v].addr, VEC[v].data, 1'b0, 3'd2, int'(VEC[v].wt), VEC[v].er);
            chk(res_low[0] == int'(VEC[v].wt) + 2 + int'(VEC[v].er), "R7 hold length",
                64'(res_low[0]), 64'(int'(VEC[v].wt) + 2 + int'(VEC[v].er)));
            chk(res_resp[0] == VEC[v].er, "R8 response in final cycle", 64'(res_resp[0]), 64'(VEC[v].er));
            chk(res_errlow[0] == VEC[v].er, "R8 first ERROR cycle with ready low",
                64'(res_errlow[0]), 64'(VEC[v].er));
            chk(log_n == base_log + 1, "R3 one peripheral access", 64'(log_n - base_log), 1);
            chk(log_addr[base_log % 16] == VEC[v].addr, "R5 captured address",
                64'(log_addr[base_log % 16]), 64'(VEC[v].addr));
            chk(log_wr[base_log % 16] == VEC[v].wr, "R5 captured direction",
                64'(log_wr[base_log % 16]), 64'(VEC[v].wr));
            chk(log_sz[base_log % 16] == 3'd2, "R5 captured size", 64'(log_sz[base_log % 16]), 2);
            if (VEC[v].wr) begin
                chk(log_data[base_log % 16] == VEC[v].data, "R6 write data",
                    64'(log_data[base_log % 16]), 64'(VEC[v].data));
            end else if (!VEC[v].er) begin
                chk(res_rd[0] == model(VEC[v].addr), "R7 read data",
                    64'(res_rd[0]), 64'(model(VEC[v].addr)));
            end
        end

        // R2: IDLE, BUSY and unselected transfers
        @(negedge clk); #1;
        base_setups = n_setups;
        base_log    = log_n;
        ahb_sel = 1'b1; ahb_trans = 2'b00; ahb_addr = 16'h0040;
        @(negedge clk); #1;
        chk(ahb_ready_out && !ahb_resp, "R2 IDLE zero-wait OKAY", 64'({ahb_ready_out, ahb_resp}), 2);
        ahb_trans = 2'b01;
        @(negedge clk); #1;
        chk(ahb_ready_out && !ahb_resp, "R2 BUSY zero-wait OKAY", 64'({ahb_ready_out, ahb_resp}), 2);
        ahb_sel = 1'b0; ahb_trans = 2'b10;
        @(negedge clk); #1;
        chk(ahb_ready_out && !dn_sel, "R2 unselected ignored", 64'({ahb_ready_out, dn_sel}), 2);
        ahb_trans = 2'b00;
        @(negedge clk); #1;
        chk(n_setups == base_setups && log_n == base_log, "R2 no peripheral access",
            64'(n_setups - base_setups), 0);

        // R9: back-to-back NONSEQ transfers with a long hold, second size differs
        base_log    = log_n;
        base_setups = n_setups;
        run_seq(2, 1'b1, 16'h0800, 32'h7700_0000, 1'b0, 3'd1, 3, 1'b0);
        chk(res_low[0] == 5, "R9 first hold length", 64'(res_low[0]), 5);
        chk(res_low[1] == 5, "R9 second starts setup straight from completion", 64'(res_low[1]), 5);
        chk(n_setups == base_setups + 2, "R9 two setups", 64'(n_setups - base_setups), 2);
        for (int i = 0; i < 2; i++) begin
            chk(log_addr[(base_log + i) % 16] == 16'h0800 + AW'(4 * i), "R9 beat address",
                64'(log_addr[(base_log + i) % 16]), 64'(16'h0800 + AW'(4 * i)));
            chk(log_data[(base_log + i) % 16] == 32'h7700_0000 + DW'(i), "R9 beat data",
                64'(log_data[(base_log + i) % 16]), 64'(32'h7700_0000 + DW'(i)));
            chk(log_sz[(base_log + i) % 16] == 3'd1, "R5 size on pipelined beat",
                64'(log_sz[(base_log + i) % 16]), 1);
        end

        // R10: SEQ write burst of four beats, then a SEQ read burst of three
        base_log = log_n;
        run_seq(4, 1'b1, 16'h0400, 32'h5000_0000, 1'b1, 3'd2, 1, 1'b0);
        for (int i = 0; i < 4; i++) begin
            chk(res_low[i] == 3, "R10 write beat hold", 64'(res_low[i]), 3);
            chk(log_addr[(base_log + i) % 16] == 16'h0400 + AW'(4 * i), "R10 write beat address",
                64'(log_addr[(base_log + i) % 16]), 64'(16'h0400 + AW'(4 * i)));
            chk(log_data[(base_log + i) % 16] == 32'h5000_0000 + DW'(i), "R10 write beat data",
                64'(log_data[(base_log + i) % 16]), 64'(32'h5000_0000 + DW'(i)));
        end
        run_seq(3, 1'b0, 16'h0A00, 32'h0, 1'b1, 3'd2, 0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            chk(res_low[i] == 2, "R10 read beat hold", 64'(res_low[i]), 2);
            chk(res_rd[i] == model(16'h0A00 + AW'(4 * i)), "R10 read beat data",
                64'(res_rd[i]), 64'(model(16'h0A00 + AW'(4 * i))));
        end

        // R1: reset in the middle of a long access
        @(negedge clk); #1;
        base_log = log_n;
        cfg_wait = 8; cfg_err = 1'b0;
        ahb_sel = 1'b1; ahb_trans = 2'b10; ahb_addr = 16'h0C00; ahb_write = 1'b1;
        @(negedge clk); #1;
        ahb_trans = 2'b00; ahb_wdata = 32'h1234_5678;
        repeat (3) @(negedge clk);
        #1;
        chk(!ahb_ready_out && dn_sel, "R1 access in progress before reset",
            64'({ahb_ready_out, dn_sel}), 1);
        rst_n = 1'b0;
        #1;
        chk(ahb_ready_out && !ahb_resp, "R1 ready and OKAY under reset", 64'({ahb_ready_out, ahb_resp}), 2);
        chk(!dn_sel && !dn_en, "R1 peripheral released under reset", 64'({dn_sel, dn_en}), 0);
        repeat (2) @(negedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(log_n == base_log, "R1 aborted access never completed", 64'(log_n - base_log), 0);

        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule